// File: doc/BRIEF.md
# Averaging PI Loop Filter for Parallel Timing Recovery

This block turns the timing errors produced by a bank of parallel timing error detectors into one control word for the numerically controlled oscillator of a parallel symbol-timing loop. Each clock it takes one error from every detector lane and adds them in a registered adder tree. It divides the total by the lane count with an arithmetic right shift, which gives the lane average. The average then passes through a proportional-integral law.

Both loop gains are negative powers of two, so each gain is a right shift. The shift amounts come from static configuration inputs. The integral branch is a saturating accumulator that advances only on cycles flagged valid. The control word is the sum of the proportional and integral branches. A valid flag travels alongside the data with the same latency.

Top module: `pi_loop_filter`

## Requirements
- R1: While reset is asserted and right after it, `ctrl_word_o` is 0 and `ctrl_valid_o` is 0. The integrator holds zero.
- R2: The average is floor(S / NUM_DET), where S is the signed sum of all NUM_DET lane errors. The control word is the proportional term plus the integrator value after this cycle's update.
- R3: The proportional term is the average shifted right arithmetically by `kp_shift_i`. The integrator increment is the average shifted right arithmetically by `ki_shift_i`. Both round toward minus infinity, so -1 stays -1.
- R4: The integrator adds its increment only for samples with `err_valid_i` = 1. On other cycles it keeps its value.
- R5: For a sample with `err_valid_i` = 0, the proportional term is zero and the control word equals the held integrator value, whatever the lane inputs carry.
- R6: A sample captured on clock edge k shows up on `ctrl_word_o` and `ctrl_valid_o` after edge k+log2(NUM_DET)+1. That is a latency of 2+log2(NUM_DET) cycles. `ctrl_valid_o` repeats `err_valid_i` with that delay.
- R7: The integrator clamps to the range [-2^(INT_W-1), 2^(INT_W-1)-1] and never wraps. It stays at a limit while further increments push outward, and it leaves the limit on the first increment of the opposite sign.
- R8: A shift amount of 0 gives unit gain. A shift amount of 15 reduces any 12-bit average to 0 or -1.
- R9: Every lane has equal weight: the same error placed on any single lane gives the same control word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| err_valid_i | input | 1 | Marks the lane errors of this cycle as a real sample |
| err_i | input | NUM_DET*ERR_W | Signed lane errors, lane j in bits [j*ERR_W +: ERR_W] |
| kp_shift_i | input | 4 | Proportional gain as a right-shift amount |
| ki_shift_i | input | 4 | Integral gain as a right-shift amount |
| ctrl_valid_o | output | 1 | Valid flag delayed with the data |
| ctrl_word_o | output | INT_W+1 | Signed control word, proportional plus integral |

## Verification
With the default of eight lanes, a sample driven before edge k belongs on the outputs after edge k+4. That is five edges when the capture edge is counted. The reference model in the bench therefore primes its expectation queue with four all-zero entries, one for each edge the pipeline needs to fill. It then pushes one expected word and flag for every driven cycle and pops one entry at each falling edge, so each comparison falls exactly on the cycle where the result becomes due. Gains are changed only after enough idle cycles to drain the pipeline. This keeps the configuration seen by every in-flight sample the same one the model used.

// File: rtl/lf_pkg.sv
package lf_pkg;
  localparam int SHIFT_W = 4;
  typedef logic [SHIFT_W-1:0] shift_t;
endpackage

// File: rtl/lf_adder_tree.sv
module lf_adder_tree #(
  parameter int NUM_DET = 8,
  parameter int ERR_W   = 12,
  localparam int LVL    = $clog2(NUM_DET),
  localparam int SUM_W  = ERR_W + LVL
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     vld_i,
  input  logic [NUM_DET*ERR_W-1:0] err_i,
  output logic                     vld_o,
  output logic signed [SUM_W-1:0]  sum_o
);
  // heap layout: 1 is root, NUM_DET..2*NUM_DET-1 are lanes
  logic signed [SUM_W-1:0] node_q [NUM_DET];
  logic signed [SUM_W-1:0] tree_v [2*NUM_DET];
  logic [LVL-1:0]          vld_q;

  for (genvar n = 0; n < 2*NUM_DET; n++) begin : g_map
    if (n == 0) begin : g_nil
      assign tree_v[n] = '0;
    end else if (n < NUM_DET) begin : g_int
      assign tree_v[n] = node_q[n];
    end else begin : g_leaf
      logic [ERR_W-1:0] lane;
      assign lane      = err_i[(n-NUM_DET)*ERR_W +: ERR_W];
      assign tree_v[n] = {{LVL{lane[ERR_W-1]}}, lane};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int n = 0; n < NUM_DET; n++) node_q[n] <= '0;
    end else begin
      node_q[0] <= '0;
      for (int n = 1; n < NUM_DET; n++) node_q[n] <= tree_v[2*n] + tree_v[2*n+1];
    end
  end

  if (LVL == 1) begin : g_v1
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) vld_q <= '0;
      else         vld_q <= vld_i;
    end
  end else begin : g_vn
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) vld_q <= '0;
      else         vld_q <= {vld_q[LVL-2:0], vld_i};
    end
  end

  assign vld_o = vld_q[LVL-1];
  assign sum_o = node_q[1];

  initial begin
    assert_pow2_R9: assert (NUM_DET >= 2 && (1 << LVL) == NUM_DET)
      else $error("lane count must be a power of two");
  end
endmodule

// File: rtl/lf_integrator.sv
module lf_integrator #(
  parameter int ERR_W = 12,
  parameter int INT_W = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    en_i,
  input  logic signed [ERR_W-1:0] inc_i,
  output logic signed [INT_W-1:0] acc_o
);
  localparam logic signed [INT_W-1:0] ACC_MAX = {1'b0, {(INT_W-1){1'b1}}};
  localparam logic signed [INT_W-1:0] ACC_MIN = {1'b1, {(INT_W-1){1'b0}}};

  logic signed [INT_W-1:0] acc_q;
  logic signed [INT_W:0]   nxt_ext;
  logic signed [INT_W-1:0] nxt_sat;

  assign nxt_ext = {acc_q[INT_W-1], acc_q} + {{(INT_W+1-ERR_W){inc_i[ERR_W-1]}}, inc_i};

  always_comb begin
    if (nxt_ext[INT_W] != nxt_ext[INT_W-1]) nxt_sat = nxt_ext[INT_W] ? ACC_MIN : ACC_MAX;
    else                                    nxt_sat = nxt_ext[INT_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   acc_q <= '0;
    else if (en_i) acc_q <= nxt_sat;
  end

  assign acc_o = acc_q;

  assert_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(acc_q));
  assert_clamp_hi_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && acc_q == ACC_MAX && !inc_i[ERR_W-1] |=> acc_q == ACC_MAX);
  assert_clamp_lo_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && acc_q == ACC_MIN && inc_i[ERR_W-1] |=> acc_q == ACC_MIN);
  assert_no_wrap_up_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !inc_i[ERR_W-1] |=> acc_q >= $past(acc_q));
  assert_no_wrap_dn_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && inc_i[ERR_W-1] |=> acc_q <= $past(acc_q));
endmodule

// File: rtl/pi_loop_filter.sv
module pi_loop_filter
  import lf_pkg::*;
#(
  parameter int NUM_DET = 8,
  parameter int ERR_W   = 12,
  parameter int INT_W   = 16,
  localparam int LVL    = $clog2(NUM_DET),
  localparam int SUM_W  = ERR_W + LVL,
  localparam int W_W    = INT_W + 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     err_valid_i,
  input  logic [NUM_DET*ERR_W-1:0] err_i,
  input  logic [SHIFT_W-1:0]       kp_shift_i,
  input  logic [SHIFT_W-1:0]       ki_shift_i,
  output logic                     ctrl_valid_o,
  output logic [W_W-1:0]           ctrl_word_o
);
  logic                    sum_vld;
  logic signed [SUM_W-1:0] sum;
  logic signed [ERR_W-1:0] avg, p_nxt, i_inc;
  logic signed [ERR_W-1:0] p_q;
  logic signed [INT_W-1:0] acc;
  logic                    v2_q, vo_q;
  logic signed [W_W-1:0]   w_q;

  lf_adder_tree #(.NUM_DET(NUM_DET), .ERR_W(ERR_W)) u_tree (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .vld_i (err_valid_i),
    .err_i (err_i),
    .vld_o (sum_vld),
    .sum_o (sum)
  );

  // averaging is a floor divide by the lane count
  assign avg   = ERR_W'(sum >>> LVL);
  assign p_nxt = avg >>> kp_shift_i;
  assign i_inc = avg >>> ki_shift_i;

  lf_integrator #(.ERR_W(ERR_W), .INT_W(INT_W)) u_int (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (sum_vld),
    .inc_i (i_inc),
    .acc_o (acc)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      p_q  <= '0;
      v2_q <= 1'b0;
      w_q  <= '0;
      vo_q <= 1'b0;
    end else begin
      p_q  <= sum_vld ? p_nxt : '0;
      v2_q <= sum_vld;
      w_q  <= W_W'(p_q) + W_W'(acc);
      vo_q <= v2_q;
    end
  end

  assign ctrl_word_o  = w_q;
  assign ctrl_valid_o = vo_q;

  assert_idle_word_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !v2_q |=> $signed(ctrl_word_o) == $signed($past(acc)));
  assert_valid_follow_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sum_vld |=> ##1 ctrl_valid_o);
endmodule

// File: tb/pi_loop_filter_tb.sv
module pi_loop_filter_tb;
  localparam int NUM_DET = 8;
  localparam int ERR_W   = 12;
  localparam int INT_W   = 16;
  localparam int LVL     = $clog2(NUM_DET);
  localparam int W_W     = INT_W + 1;
  localparam int I_MAX   = (1 << (INT_W-1)) - 1;
  localparam int I_MIN   = -(1 << (INT_W-1));

  logic                     clk = 1'b0;
  logic                     rst_ni = 1'b0;
  logic                     err_valid_i = 1'b0;
  logic [NUM_DET*ERR_W-1:0] err_i = '0;
  logic [3:0]               kp_shift_i = 4'd0;
  logic [3:0]               ki_shift_i = 4'd0;
  logic                     ctrl_valid_o;
  logic [W_W-1:0]           ctrl_word_o;

  int total = 0;
  int bad   = 0;
  int m_i   = 0;
  int kp    = 0;
  int ki    = 0;
  int cur_e [NUM_DET];
  int q_w [$];
  bit q_v [$];

  always #10 clk = ~clk;

  pi_loop_filter #(.NUM_DET(NUM_DET), .ERR_W(ERR_W), .INT_W(INT_W)) u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .err_valid_i (err_valid_i),
    .err_i       (err_i),
    .kp_shift_i  (kp_shift_i),
    .ki_shift_i  (ki_shift_i),
    .ctrl_valid_o(ctrl_valid_o),
    .ctrl_word_o (ctrl_word_o)
  );

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic set_all(int v);
    for (int j = 0; j < NUM_DET; j++) cur_e[j] = v;
  endtask

  task automatic prime();
    q_w.delete(); q_v.delete();
    m_i = 0;
    for (int j = 0; j <= LVL; j++) begin q_w.push_back(0); q_v.push_back(1'b0); end
  endtask

  // called at a falling edge: drive, model, wait one cycle, compare
  task automatic step(bit v, string tag);
    int s, avg, p, w;
    s = 0;
    for (int j = 0; j < NUM_DET; j++) begin
      err_i[j*ERR_W +: ERR_W] = cur_e[j][ERR_W-1:0];
      s += cur_e[j];
    end
    err_valid_i = v;
    avg = s >>> LVL;
    p = v ? (avg >>> kp) : 0;
    if (v) begin
      m_i = m_i + (avg >>> ki);
      if (m_i > I_MAX) m_i = I_MAX;
      if (m_i < I_MIN) m_i = I_MIN;
    end
    q_w.push_back(p + m_i);
    q_v.push_back(v);
    @(negedge clk);
    w = q_w.pop_front();
    check(tag, int'($signed(ctrl_word_o)), w);
    check("R6", int'(ctrl_valid_o), int'(q_v.pop_front()));
  endtask

  task automatic run(bit v, int n, string tag);
    for (int c = 0; c < n; c++) step(v, tag);
  endtask

  task automatic set_gain(int p, int i);
    run(1'b0, LVL + 2, "R5");
    kp = p; ki = i;
    kp_shift_i = 4'(p); ki_shift_i = 4'(i);
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    err_valid_i = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", int'($signed(ctrl_word_o)), 0);
    check("R1", int'(ctrl_valid_o), 0);
    rst_ni = 1'b1;
    prime();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    set_all(0);
    kp = 1; ki = 3; kp_shift_i = 4'd1; ki_shift_i = 4'd3;
    @(negedge clk);
    do_reset();
    run(1'b0, 2, "R1");

    // R2: uniform lanes, single sample then drain
    set_all(10);
    run(1'b1, 1, "R2");
    set_all(0);
    run(1'b0, 6, "R2");
    set_all(24);
    run(1'b1, 3, "R2");

    // R9: same error on different single lanes
    set_all(0); cur_e[0] = 40;
    run(1'b1, 1, "R9");
    set_all(0); cur_e[NUM_DET-1] = 40;
    run(1'b1, 1, "R9");
    set_all(0); cur_e[3] = 40;
    run(1'b1, 1, "R9");

    // R3: floor rounding on negative values
    set_gain(3, 3);
    set_all(0); cur_e[2] = -1;
    run(1'b1, 2, "R3");
    cur_e = '{100, -37, 5, -300, 77, 0, -2, 9};
    run(1'b1, 2, "R3");
    set_all(-15);
    run(1'b1, 2, "R3");

    // R5 and R4: invalid samples with busy lanes
    set_all(500);
    run(1'b0, 5, "R5");
    run(1'b0, 1, "R4");

    // R8: extreme shift amounts
    set_gain(0, 15);
    set_all(1000);
    run(1'b1, 3, "R8");
    set_all(-1000);
    run(1'b1, 3, "R8");
    set_gain(15, 0);
    set_all(-7);
    run(1'b1, 2, "R8");
    set_all(7);
    run(1'b1, 2, "R8");

    // R7: upper clamp, then leave it
    set_gain(0, 0);
    set_all(2047);
    run(1'b1, 22, "R7");
    set_all(-2048);
    run(1'b1, 3, "R7");

    // R7: lower clamp after a fresh reset
    do_reset();
    set_all(-2048);
    run(1'b1, 22, "R7");
    set_all(300);
    run(1'b1, 2, "R7");
    run(1'b0, LVL + 2, "R4");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule